// File: doc/BRIEF.md
# SPI Serial Flash Read Responder

This block is the target-side command logic of a serial NOR flash, limited to two instructions: a byte-addressed data read and an identification read. A bus controller selects the device by pulling chip select low, clocks in an 8-bit opcode and, for a data read, a 24-bit address. The block then streams bytes on its serial output for as long as the controller keeps clocking. Data reads advance through an internal byte array and wrap from its top back to zero. The identification read returns a fixed 20-byte record whose fourth byte gives the length of the rest.

The serial pins are sampled by a faster system clock through synchronizers, and the edges of the serial clock are detected in that domain. The byte array is a parameterised synchronous memory. A system-side write port fills it before use. The output driver is modelled as a data bit plus an enable, and the enable is low whenever the line should be high-impedance.

Top module: `spi_flash_rd`

## Requirements
- R1: While chip select is high, `sdo_oe` is low, and serial clock or data activity has no effect: a transaction that follows behaves as if that activity never happened.
- R2: Opcode 03h followed by a 24-bit address, both MSB first and sampled on serial clock rising edges, returns the byte stored at that address MSB first. Each bit changes after a serial clock falling edge, and the first bit follows the falling edge that comes after the last address bit.
- R3: After each complete output byte of a data read, the address advances by one, and the next byte follows with no gap.
- R4: After the byte at the highest array address (2^AW − 1), the next byte comes from address 0, and streaming continues indefinitely.
- R5: Address bits at and above position AW are shifted in but ignored.
- R6: Opcode 9Fh returns bytes 0 to 3 as 20h, BAh, 18h and 10h, where 10h is the count of the bytes that follow.
- R7: Identification byte 4 encodes the configuration: bits [1:0] carry the architecture code (00 uniform, 01 bottom, 11 top), bit 3 the shared-pin function (0 hold, 1 reset), bit 4 the execute-in-place requirement flag, and all other bits are 0. Identification bytes 5 to 19 are 00h.
- R8: Identification bytes after the 20th are 00h.
- R9: Any opcode other than 03h or 9Fh keeps `sdo_oe` low until chip select next goes high, and the next transaction works normally.
- R10: Chip select going high at any point, including mid-byte, drops `sdo_oe` within 4 system clocks. The next read starts fresh from its own address.
- R11: `sdo_oe` stays low during the opcode and address phases. It rises only once the command is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in (opcode and address) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable; low means high-impedance |
| ld_we | input | 1 | Array load write enable |
| ld_addr | input | AW | Array load address |
| ld_data | input | 8 | Array load data |

## Verification
The array is filled with an address-dependent pattern, so each returned byte shows which address it came from. A short read from a low address checks MSB-first ordering and single-step advance. A read that starts a few bytes below the top tells a correct wrap from an overrun or a stall. A read longer than the whole array shows that streaming never stops on its own. A start address with junk in its upper bits separates proper truncation from use of the full address. The identification read runs past its 20 defined bytes, which checks the fixed header, the configuration byte, the zero fill and the zero tail. An unknown opcode, clock activity while deselected, and a deselect in the middle of a byte each check that the output stays released, and each is followed by a normal read that checks nothing was left behind.

// File: rtl/spi_flash_rd_pkg.sv
package spi_flash_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP,
    ST_ADR,
    ST_DAT,
    ST_IGN
  } st_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam int         ID_LEN   = 20;
  localparam int         IDX_W    = 5;
  localparam int         ADR_BITS = 24;
  localparam int         OPC_BITS = 8;

  // configuration byte: arch in [1:0], pin function in [3], xip flag in [4]
  function automatic logic [7:0] ext_id0(input logic [1:0] arch,
                                         input logic hold_rst,
                                         input logic xip_req);
    return {3'b000, xip_req, hold_rst, 1'b0, arch};
  endfunction

  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] idx,
                                         input logic [7:0] ext0);
    logic [7:0] b;
    case (idx)
      5'd0:    b = 8'h20;
      5'd1:    b = 8'hBA;
      5'd2:    b = 8'h18;
      5'd3:    b = 8'h10;
      5'd4:    b = ext0;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(ID_LEN)) ? idx : idx + 5'd1;
  endfunction

endpackage

// File: rtl/spi_flash_rd_front.sv
module spi_flash_rd_front #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_idle,
  output logic rise_evt,
  output logic fall_evt,
  output logic sdi_s
);

  logic [SYNC_N-1:0] cs_q, ck_q, di_q;
  logic              ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '1;
      ck_q <= '0;
      di_q <= '0;
      ck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[SYNC_N-2:0], cs_n};
      ck_q <= {ck_q[SYNC_N-2:0], sclk};
      di_q <= {di_q[SYNC_N-2:0], sdi};
      ck_d <= ck_q[SYNC_N-1];
    end
  end

  assign cs_idle  = cs_q[SYNC_N-1];
  assign sdi_s    = di_q[SYNC_N-1];
  assign rise_evt = ck_q[SYNC_N-1] & ~ck_d;
  assign fall_evt = ~ck_q[SYNC_N-1] & ck_d;

endmodule

// File: rtl/spi_flash_rd_ctrl.sv
module spi_flash_rd_ctrl
  import spi_flash_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_idle,
  input  logic          rise_evt,
  input  logic          sdi_s,
  output logic          op_done,
  output logic          bad_op,
  output logic          start,
  output logic          mode_rd,
  output logic [AW-1:0] start_addr
);

  localparam int CNT_W = $clog2(ADR_BITS);

  st_t                 st;
  logic [CNT_W-1:0]    cnt;
  logic [ADR_BITS-1:0] sh, sh_nx;
  logic                mode_q;
  logic                cmd_ph, adr_done;
  logic [7:0]          op_val;

  assign sh_nx    = {sh[ADR_BITS-2:0], sdi_s};
  assign cmd_ph   = (st == ST_IDLE || st == ST_OP) && !cs_idle;
  assign op_val   = sh_nx[7:0];
  assign op_done  = cmd_ph && rise_evt && (cnt == CNT_W'(OPC_BITS - 1));
  assign bad_op   = op_done && (op_val != OP_READ) && (op_val != OP_IDENT);
  assign adr_done = (st == ST_ADR) && !cs_idle && rise_evt
                    && (cnt == CNT_W'(ADR_BITS - 1));
  assign start    = adr_done || (op_done && op_val == OP_IDENT);
  assign start_addr = sh_nx[AW-1:0];
  assign mode_rd  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      mode_q <= 1'b0;
    end else if (cs_idle) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_OP: begin
          st <= ST_OP;
          if (rise_evt) begin
            sh  <= sh_nx;
            cnt <= cnt + CNT_W'(1);
          end
          if (op_done) begin
            cnt <= '0;
            if (op_val == OP_READ) begin
              st     <= ST_ADR;
              mode_q <= 1'b1;
            end else if (op_val == OP_IDENT) begin
              st     <= ST_DAT;
              mode_q <= 1'b0;
            end else begin
              st <= ST_IGN;
            end
          end
        end
        ST_ADR: begin
          if (rise_evt) begin
            sh  <= sh_nx;
            cnt <= cnt + CNT_W'(1);
          end
          if (adr_done) st <= ST_DAT;
        end
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/spi_flash_rd_array.sv
module spi_flash_rd_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_flash_rd_tx.sv
module spi_flash_rd_tx
  import spi_flash_rd_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [1:0] ARCH     = 2'b11,
  parameter logic       HOLD_RST = 1'b0,
  parameter logic       XIP_REQ  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_idle,
  input  logic             fall_evt,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic             mode_rd,
  input  logic [7:0]       mem_q,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             byte_done,
  output logic [AW-1:0]    rd_addr,
  output logic [IDX_W-1:0] id_idx
);

  localparam logic [7:0] EXT0  = ext_id0(ARCH, HOLD_RST, XIP_REQ);
  localparam int         BIT_W = 3;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic             active;
  logic [BIT_W-1:0] bidx;
  logic [7:0]       cur;
  logic             ld1, ld2;
  logic             sdo_q;

  assign byte_done = active && !cs_idle && fall_evt && (bidx == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bidx    <= '0;
      cur     <= '0;
      ld1     <= 1'b0;
      ld2     <= 1'b0;
      rd_addr <= '0;
      id_idx  <= '0;
      sdo_q   <= 1'b0;
    end else begin
      ld2 <= ld1;
      ld1 <= 1'b0;
      if (cs_idle) begin
        active <= 1'b0;
      end else if (start) begin
        active  <= 1'b1;
        rd_addr <= start_addr;
        id_idx  <= '0;
        bidx    <= '0;
        ld1     <= 1'b1;
      end else if (active && fall_evt) begin
        sdo_q <= cur[3'd7 - bidx];
        bidx  <= bidx + 3'd1;
        if (byte_done) begin
          rd_addr <= addr_step(rd_addr);
          id_idx  <= idx_step(id_idx);
          ld1     <= 1'b1;
        end
      end
      if (ld2) cur <= mode_rd ? mem_q : id_byte(id_idx, EXT0);
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = active;

endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
  import spi_flash_rd_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [1:0] ARCH     = 2'b11,
  parameter logic       HOLD_RST = 1'b0,
  parameter logic       XIP_REQ  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data
);

  logic             cs_idle, rise_evt, fall_evt, sdi_s;
  logic             op_done, bad_op, start, mode_rd, byte_done;
  logic [AW-1:0]    start_addr, rd_addr;
  logic [7:0]       mem_q;
  logic [IDX_W-1:0] id_idx;

  spi_flash_rd_front #(.SYNC_N(2)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_idle(cs_idle), .rise_evt(rise_evt), .fall_evt(fall_evt), .sdi_s(sdi_s)
  );

  spi_flash_rd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .rise_evt(rise_evt),
    .sdi_s(sdi_s), .op_done(op_done), .bad_op(bad_op), .start(start),
    .mode_rd(mode_rd), .start_addr(start_addr)
  );

  spi_flash_rd_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
    .raddr(rd_addr), .rdata(mem_q)
  );

  spi_flash_rd_tx #(.AW(AW), .ARCH(ARCH), .HOLD_RST(HOLD_RST), .XIP_REQ(XIP_REQ)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .fall_evt(fall_evt),
    .start(start), .start_addr(start_addr), .mode_rd(mode_rd), .mem_q(mem_q),
    .sdo(sdo), .sdo_oe(sdo_oe), .byte_done(byte_done), .rd_addr(rd_addr),
    .id_idx(id_idx)
  );

endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk
  import spi_flash_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_idle,
  input logic             fall_evt,
  input logic             start,
  input logic             bad_op,
  input logic             byte_done,
  input logic             mode_rd,
  input logic [AW-1:0]    rd_addr,
  input logic [IDX_W-1:0] id_idx,
  input logic             sdo,
  input logic             sdo_oe
);

  localparam logic [AW-1:0] ONE = AW'(1);

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !sdo_oe);

  a_r2_bit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(fall_evt)) |-> $stable(sdo));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && mode_rd) |=> (rd_addr == $past(rd_addr) + ONE));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && mode_rd && (&rd_addr)) |=> (rd_addr == '0));

  a_r8_id_cap: assert property (@(posedge clk) disable iff (!rst_n)
    id_idx <= IDX_W'(ID_LEN));

  a_r9_bad_op_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> !sdo_oe);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_idle) |=> !sdo_oe);

  a_r11_oe_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(start));

endmodule

bind spi_flash_rd spi_flash_rd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .fall_evt(fall_evt),
  .start(start), .bad_op(bad_op), .byte_done(byte_done), .mode_rd(mode_rd),
  .rd_addr(rd_addr), .id_idx(id_idx), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/spi_flash_rd_bench.sv
module spi_flash_rd_bench;

  localparam int         AW    = 8;
  localparam int         DEPTH = 1 << AW;
  localparam int         HP    = 8;
  localparam logic [1:0] ARCH  = 2'b11;
  localparam logic       HOLD  = 1'b0;
  localparam logic       XIP   = 1'b1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b0;
  logic          sdi = 1'b0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic          sdo, sdo_oe;

  always #5 clk = ~clk;

  spi_flash_rd #(.AW(AW), .ARCH(ARCH), .HOLD_RST(HOLD), .XIP_REQ(XIP)) u_spi_flash_rd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_q [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each produced byte against the expected queue
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string      t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {24'h0, g}, {24'h0, e});
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] cfg;
    cfg = 8'((XIP ? 16 : 0) + (HOLD ? 8 : 0) + int'(ARCH));
    case (i)
      0: return 8'h20;
      1: return 8'hBA;
      2: return 8'h18;
      3: return 8'h10;
      4: return cfg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic bit_cyc(input logic din, output logic dout);
    @(negedge clk) sdi = din;
    repeat (HP - 1) @(negedge clk);
    dout = sdo;
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], d);
  endtask

  task automatic recv(input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) bit_cyc(1'b0, v[i]);
      got_q.push_back(v);
    end
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk) cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic push_rd(input logic [23:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(int'(a) + i) % DEPTH]);
      tag_q.push_back(tag);
    end
  endtask

  task automatic rd_txn(input logic [23:0] a, input int n, input string tag);
    push_rd(a, n, tag);
    sel();
    send_byte(8'h03);
    send_byte(a[23:16]);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    recv(n);
    desel();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic d;
    repeat (5) @(negedge clk);
    check("R1 reset oe", {31'h0, sdo_oe}, 32'h0);
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_we = 1'b1;
      ld_addr = AW'(a);
      ld_data = pat(a);
      model[a] = pat(a);
    end
    @(negedge clk) ld_we = 1'b0;

    // R1: serial activity while deselected
    send_byte(8'h03);
    check("R1 standby oe", {31'h0, sdo_oe}, 32'h0);
    send_byte(8'h00);
    send_byte(8'h40);
    check("R1 standby oe", {31'h0, sdo_oe}, 32'h0);
    rd_txn(24'h000010, 4, "R1 R2 R3 read");

    // R11: enable timing across the command phases
    push_rd(24'h000040, 2, "R11 read");
    sel();
    send_byte(8'h03);
    check("R11 oe in opcode phase", {31'h0, sdo_oe}, 32'h0);
    send_byte(8'h00);
    send_byte(8'h00);
    check("R11 oe in address phase", {31'h0, sdo_oe}, 32'h0);
    send_byte(8'h40);
    repeat (4) @(negedge clk);
    check("R11 oe after address", {31'h0, sdo_oe}, 32'h1);
    recv(2);
    desel();
    check("R10 oe after deselect", {31'h0, sdo_oe}, 32'h0);

    // R5: upper address bits ignored
    rd_txn(24'hAB00F0, 3, "R5 upper bits");

    // R4: wrap near the top, then a stream longer than the array
    rd_txn(24'h0000FD, 6, "R4 wrap");
    rd_txn(24'h000080, DEPTH + 4, "R4 long stream");

    // R6 R7 R8: identification stream past its defined length
    for (int i = 0; i < 24; i++) begin
      exp_q.push_back(exp_id(i));
      tag_q.push_back(i < 4 ? "R6 id header" : (i < 20 ? "R7 id config" : "R8 id tail"));
    end
    sel();
    send_byte(8'h9F);
    recv(24);
    desel();

    // R9: unknown opcode
    sel();
    send_byte(8'h05);
    for (int i = 0; i < 16; i++) begin
      bit_cyc(1'b0, d);
      check("R9 unknown opcode oe", {31'h0, sdo_oe}, 32'h0);
    end
    desel();
    rd_txn(24'h000033, 2, "R9 after unknown");

    // R10: deselect mid-byte
    push_rd(24'h000020, 1, "R10 before abort");
    sel();
    send_byte(8'h03);
    send_byte(8'h00);
    send_byte(8'h00);
    send_byte(8'h20);
    recv(1);
    for (int i = 0; i < 3; i++) bit_cyc(1'b0, d);
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 oe after mid-byte deselect", {31'h0, sdo_oe}, 32'h0);
    repeat (4) @(negedge clk);
    rd_txn(24'h000021, 2, "R10 after abort");

    repeat (30) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 32'h0);
    summary();
    $finish;
  end

endmodule